// File: doc/BRIEF.md
# Serial Character Transmitter with Line Break

This block turns a stream of characters into an asynchronous serial line. Characters go into a sixteen-entry queue over a valid/ready handshake. A framing engine takes them from the queue one at a time. Each character goes out as a low start bit, then five to eight data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The engine is paced by an external strobe that pulses sixteen times per bit period. Every bit takes exactly sixteen strobes.

A line control word sets the frame format at run time. The engine captures the format when it takes a character from the queue, so a change to the control word only affects later characters. One bit of the control word holds the line at the low break level for as long as it is set. A global enable pin gates all activity: while it is low the line idles high, strobes are ignored and no new character starts. Status pins report whether the block is busy, whether the queue is full and whether it is empty. A level request asks for more data while the block is enabled and the queue has room.

Back-pressure on the input stream works as follows. A character is transferred on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low exactly while the queue holds sixteen characters. A source that holds `in_valid` high while `in_ready` is low waits with its character. A character withdrawn before it is accepted is never written.

Top module: `serial_tx_engine`

## Requirements
- R1: After reset, `txd` is 1, `in_ready` is 1, `flags` reads 8'h80 (queue empty, not busy) and `tx_irq` is 0 while `en` is 0.
- R2: A frame is a 0 start bit followed by data bits, least significant first. The number of data bits is set by `line_ctl[6:5]`: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Every bit lasts 16 `tick16` pulses. `txd` shows each bit one clock after the engine enters it, and the line is 1 between frames.
- R3: When `line_ctl[1]` is 1, a parity bit follows the data bits. It is computed over the configured data bits only. With `line_ctl[2]`=1 it makes the count of ones even; with 0 it makes the count odd.
- R4: When `line_ctl[3]` is 1, two stop bits of value 1 end the frame (32 pulses); when it is 0, one stop bit does.
- R5: While `en` is 1 and `line_ctl[0]` is 1, `txd` is 0 from the next clock. The frame timing underneath keeps running.
- R6: While `en` is 0, `txd` is 1 from the next clock, `tick16` pulses are ignored and no character is taken from the queue. A frame that was in progress continues where it stopped once `en` returns to 1.
- R7: The queue holds 16 characters in arrival order. `in_ready` is 0 while it is full, and a character offered while it is full is not stored.
- R8: `flags[3]` (busy) is 1 while any character is queued or still being framed, up to the end of its last stop bit. `flags[5]` is 1 when the queue is full. `flags[7]` is 1 when the queue is empty. All other bits of `flags` are 0.
- R9: `tx_irq` is 1 exactly when `en` is 1 and the queue is not full.
- R10: The data length, parity and stop settings are captured when a character leaves the queue. Changing `line_ctl` during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Strobe at sixteen times the bit rate, one clock wide |
| en | input | 1 | Global enable |
| line_ctl | input | 8 | Break [0], parity on [1], even parity [2], two stops [3], data length code [6:5] |
| in_valid | input | 1 | Input character valid |
| in_ready | output | 1 | Queue can accept a character |
| in_data | input | 8 | Input character |
| txd | output | 1 | Serial line, idle high |
| flags | output | 8 | Busy [3], full [5], empty [7] |
| tx_irq | output | 1 | Request for more data |

## Verification
`in_ready`, `flags` and `tx_irq` are decoded from state, so they are due right after the rising edge that updated the queue or the engine. `tx_irq` also follows `en` within the same cycle. `txd` is registered, so it shows a bit one clock after the engine enters that bit, and it reacts to `en` or the break bit one clock after they change. A behavioural model in the bench takes the same inputs at each rising edge. Every falling edge then compares all outputs with the model. Inputs change shortly after the falling edge, so each value is sampled halfway between the edge that produced it and the next edge.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  localparam int DATA_W    = 8;
  localparam int BIT_TICKS = 16;

  // line control word positions
  localparam int LC_BREAK    = 0;
  localparam int LC_PAR_ON   = 1;
  localparam int LC_PAR_EVEN = 2;
  localparam int LC_TWO_STOP = 3;
  localparam int LC_WL_LO    = 5;
  localparam int LC_WL_HI    = 6;

  // status word positions
  localparam int FL_BUSY  = 3;
  localparam int FL_FULL  = 5;
  localparam int FL_EMPTY = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] wl;
    logic       par_on;
    logic       par_even;
    logic       two_stop;
  } frame_fmt_t;

  function automatic logic [DATA_W-1:0] wl_mask(input logic [1:0] wl);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i < int'(wl) + 5);
    return m;
  endfunction
endpackage

// File: rtl/stx_fifo.sv
module stx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/stx_framer.sv
module stx_framer
  import serial_tx_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic         avail,
  input  logic [W-1:0] data,
  input  frame_fmt_t   fmt,
  output logic         pop,
  output logic         active,
  output logic         line_bit
);
  localparam int TW = $clog2(BIT_TICKS);
  localparam int IW = (W > 1) ? $clog2(W) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(BIT_TICKS - 1);

  tx_state_e     state;
  logic [TW-1:0] tcnt;
  logic [IW-1:0] bidx, last_idx;
  logic [W-1:0]  shreg;
  logic          pbit, par_on, two_stop, second_stop;
  logic          bit_done;

  assign pop      = (state == ST_IDLE) && en && avail;
  assign active   = (state != ST_IDLE);
  assign bit_done = en && tick && (tcnt == TICK_LAST);

  always_comb begin
    case (state)
      ST_START:  line_bit = 1'b0;
      ST_DATA:   line_bit = shreg[0];
      ST_PARITY: line_bit = pbit;
      default:   line_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      tcnt        <= '0;
      bidx        <= '0;
      last_idx    <= '0;
      shreg       <= '0;
      pbit        <= 1'b0;
      par_on      <= 1'b0;
      two_stop    <= 1'b0;
      second_stop <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (pop) begin
        shreg    <= data;
        last_idx <= IW'(int'(fmt.wl) + 4);
        par_on   <= fmt.par_on;
        two_stop <= fmt.two_stop;
        pbit     <= (^(data & wl_mask(fmt.wl))) ~^ fmt.par_even;
        tcnt     <= '0;
        state    <= ST_START;
      end
    end else if (en && tick) begin
      tcnt <= bit_done ? '0 : tcnt + 1'b1;
      if (bit_done) begin
        case (state)
          ST_START: begin
            bidx  <= '0;
            state <= ST_DATA;
          end
          ST_DATA: begin
            shreg <= shreg >> 1;
            if (bidx == last_idx) begin
              second_stop <= 1'b0;
              state       <= par_on ? ST_PARITY : ST_STOP;
            end else begin
              bidx <= bidx + 1'b1;
            end
          end
          ST_PARITY: begin
            second_stop <= 1'b0;
            state       <= ST_STOP;
          end
          ST_STOP: begin
            if (two_stop && !second_stop) second_stop <= 1'b1;
            else                          state       <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/stx_line_drive.sv
module stx_line_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic brk,
  input  logic line_bit,
  output logic txd
);
  always_ff @(posedge clk) begin
    if (!rst_n)   txd <= 1'b1;
    else if (!en) txd <= 1'b1;
    else if (brk) txd <= 1'b0;
    else          txd <= line_bit;
  end
endmodule

// File: rtl/serial_tx_engine.sv
module serial_tx_engine
  import serial_tx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              en,
  input  logic [7:0]        line_ctl,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              txd,
  output logic [7:0]        flags,
  output logic              tx_irq
);
  logic              q_full, q_empty, q_pop, eng_active, eng_bit;
  logic [DATA_W-1:0] q_data;
  frame_fmt_t        fmt;
  logic              unused_ctl_bits;

  assign unused_ctl_bits = line_ctl[4] ^ line_ctl[7];

  assign fmt.wl       = line_ctl[LC_WL_HI:LC_WL_LO];
  assign fmt.par_on   = line_ctl[LC_PAR_ON];
  assign fmt.par_even = line_ctl[LC_PAR_EVEN];
  assign fmt.two_stop = line_ctl[LC_TWO_STOP];

  assign in_ready = !q_full;
  assign tx_irq   = en && !q_full;

  always_comb begin
    flags           = '0;
    flags[FL_BUSY]  = eng_active || !q_empty;
    flags[FL_FULL]  = q_full;
    flags[FL_EMPTY] = q_empty;
  end

  stx_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (in_valid && !q_full),
    .wdata (in_data),
    .pop   (q_pop),
    .rdata (q_data),
    .full  (q_full),
    .empty (q_empty)
  );

  stx_framer #(.W(DATA_W)) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .tick     (tick16),
    .avail    (!q_empty),
    .data     (q_data),
    .fmt      (fmt),
    .pop      (q_pop),
    .active   (eng_active),
    .line_bit (eng_bit)
  );

  stx_line_drive u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .brk      (line_ctl[LC_BREAK]),
    .line_bit (eng_bit),
    .txd      (txd)
  );
endmodule

// File: rtl/serial_tx_engine_chk.sv
module serial_tx_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       brk,
  input logic       in_valid,
  input logic       in_ready,
  input logic       txd,
  input logic [7:0] flags,
  input logic       tx_irq
);
  assert_idle_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> txd);

  assert_break_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && brk) |=> !txd);

  assert_quiet_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !brk && !flags[3]) |=> txd);

  assert_busy_queue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !flags[7] |-> flags[3]);

  assert_flag_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags[5] && flags[7]));

  assert_push_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !flags[7]);

  assert_irq_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> (!flags[5] && en));
endmodule

bind serial_tx_engine serial_tx_engine_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .brk      (line_ctl[0]),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .txd      (txd),
  .flags    (flags),
  .tx_irq   (tx_irq)
);

// File: tb/serial_tx_engine_test.sv
module serial_tx_engine_test;
  logic       clk = 0, rst_n = 0, tick16 = 0, en = 0, in_valid = 0;
  logic [7:0] line_ctl = 8'h60, in_data = 0;
  logic       in_ready, txd, tx_irq;
  logic [7:0] flags;

  int checks = 0, errors = 0, cyc = 0;
  string tag = "R1";

  serial_tx_engine uut (.*);

  always #10 clk = ~clk;

  // reference model state
  byte unsigned mq[$];
  int  m_st = 0, m_t = 0, m_b = 0, m_nb = 8, m_s = 0;
  logic [7:0] m_sh;
  logic m_pe = 0, m_pv = 0, m_ts = 0, m_txd = 1;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mq.delete(); m_st = 0; m_txd = 1;
    end else begin
      logic lb, do_pop, do_push;
      logic [7:0] d, msk;
      lb = (m_st == 1) ? 1'b0 : (m_st == 2) ? m_sh[0] : (m_st == 3) ? m_pv : 1'b1;
      do_pop  = (m_st == 0) && en && (mq.size() > 0);
      do_push = in_valid && (mq.size() < 16);
      if (m_st == 0) begin
        if (do_pop) begin
          d = mq.pop_front();
          m_sh = d; m_nb = int'(line_ctl[6:5]) + 5;
          msk = 8'((1 << m_nb) - 1);
          m_pe = line_ctl[1]; m_ts = line_ctl[3];
          m_pv = line_ctl[2] ? ^(d & msk) : ~^(d & msk);
          m_st = 1; m_t = 0;
        end
      end else if (en && tick16) begin
        if (m_t == 15) begin
          m_t = 0;
          case (m_st)
            1: begin m_st = 2; m_b = 0; end
            2: begin
              m_sh = m_sh >> 1;
              if (m_b == m_nb - 1) begin m_s = 0; m_st = m_pe ? 3 : 4; end
              else m_b++;
            end
            3: begin m_s = 0; m_st = 4; end
            default: if (m_ts && m_s == 0) m_s = 1; else m_st = 0;
          endcase
        end else m_t++;
      end
      if (do_push) mq.push_back(in_data);
      m_txd = !en ? 1'b1 : line_ctl[0] ? 1'b0 : lb;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // cycle compare against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0] ef;
      ef = 8'h00;
      ef[7] = (mq.size() == 0);
      ef[5] = (mq.size() == 16);
      ef[3] = (m_st != 0) || (mq.size() > 0);
      chk(tag, "txd", int'(txd), int'(m_txd));
      chk("R7", "in_ready", int'(in_ready), int'(mq.size() < 16));
      chk("R8", "flags", int'(flags), int'(ef));
      chk("R9", "tx_irq", int'(tx_irq), int'(en && mq.size() < 16));
    end
  end

  // tick every third clock
  initial begin
    int k = 0;
    forever begin
      @(negedge clk); #1;
      tick16 = (k % 3 == 0);
      k++;
    end
  end

  task automatic step(); @(negedge clk); #2; endtask

  task automatic push(logic [7:0] d);
    logic ok;
    step();
    in_valid = 1; in_data = d;
    for (int i = 0; i < 20000; i++) begin
      ok = in_ready;
      @(posedge clk);
      if (ok) break;
    end
    step();
    in_valid = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!flags[3]) break;
    end
    #2;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) step();
    // R1 reset state
    chk("R1", "txd", int'(txd), 1);
    chk("R1", "flags", int'(flags), 8'h80);
    chk("R1", "in_ready", int'(in_ready), 1);
    chk("R1", "tx_irq", int'(tx_irq), 0);
    rst_n = 1;
    step();

    // R7: fill queue while disabled, then offer one more
    tag = "R7";
    for (int i = 0; i < 16; i++) push(8'(8'h31 + i * 7));
    in_valid = 1; in_data = 8'hEE;
    repeat (4) step();
    in_valid = 0;
    chk("R7", "in_ready full", int'(in_ready), 0);
    chk("R8", "flags full", int'(flags), 8'h28);
    chk("R9", "irq disabled", int'(tx_irq), 0);

    // R2: 8 data bits, no parity, one stop; R10 change mid-frame
    tag = "R2";
    en = 1;
    repeat (100) step();
    tag = "R10";
    line_ctl = 8'h0A;
    repeat (2000) step();
    tag = "R3";
    line_ctl = 8'h46;
    wait_idle();
    chk("R8", "drained", int'(flags), 8'h80);

    // R4: 6 data bits, two stops
    tag = "R4";
    line_ctl = 8'h28;
    push(8'h3C); push(8'h15); push(8'h2A);
    wait_idle();

    // R3: parity variants over 8 bits and 5 bits
    tag = "R3";
    line_ctl = 8'h66; push(8'hA5); push(8'h01); wait_idle();
    line_ctl = 8'h62; push(8'hE3); push(8'h00); wait_idle();
    line_ctl = 8'h06; push(8'hF0); wait_idle();

    // R5: break during a frame
    tag = "R5";
    line_ctl = 8'h60;
    push(8'h55); push(8'hAA);
    repeat (150) step();
    line_ctl = 8'h61;
    repeat (200) step();
    chk("R5", "break level", int'(txd), 0);
    line_ctl = 8'h60;
    wait_idle();

    // R6: disable mid-frame, resume
    tag = "R6";
    push(8'h0F); push(8'hC3);
    repeat (120) step();
    en = 0;
    repeat (300) step();
    chk("R6", "line high", int'(txd), 1);
    chk("R6", "still busy", int'(flags[3]), 1);
    en = 1;
    wait_idle();
    chk("R9", "irq room", int'(tx_irq), 1);
    chk("R2", "idle line", int'(txd), 1);
    finish_run();
  end
endmodule